// File: doc/BRIEF.md
# Lockable Memory Window Decoder

This block decides whether a 32-bit bus address falls inside one programmable memory window. The window is described by an inclusive lower bound and an inclusive upper bound. Each bound is a 16-bit value that is compared against address bits 31:16, so the window has 64 KB granularity. Two bound registers and a lock register sit behind a small strobe-based register port. The decoder output `win_hit` is combinational in the incoming address.

The bounds are protected by a lock. A bound write takes effect only while the unlock bit is set. Any write to either bound clears the unlock bit in the same cycle, so every later bound write needs a fresh unlock.

The window is reported as disabled while the upper bound is zero or the lower bound exceeds the upper bound. Software relies on this: it first raises the lower bound above the upper bound, then reprograms the window without ever exposing a partial range. The asynchronous reset input is synchronised internally. The block leaves reset two clock edges after `rst_n` rises.

Top module: `mem_window_decode`

## Requirements
- R1: After reset, both bounds and the unlock bit are 0, `win_en` and `win_hit` are 0, and `reg_rdata` is 0.
- R2: A write to a bound register while the unlock bit is 0 is ignored, and the bound keeps its value.
- R3: A bound write clears the unlock bit in the same cycle. A second bound write without a new unlock is ignored.
- R4: Writing the lock register at byte offset 0x8 loads wdata bit 0 into the unlock bit. Reading that register returns the unlock bit in bit 0 and zeros in bits 31:1.
- R5: The lower bound sits at offset 0x0 and the upper bound at offset 0x4, each in bits 31:16. Reads of bits 15:0 return 0. Any other offset reads as 0, and writes to it change nothing.
- R6: `reg_rdata` takes the addressed register value at the clock edge that samples `reg_rd`, and holds that value until the next read.
- R7: `win_en` is 1 exactly when the upper bound is non-zero and the lower bound is not greater than the upper bound.
- R8: `win_hit` is 1 exactly when `win_en` is 1 and lower ≤ `bus_addr[31:16]` ≤ upper, with both comparisons inclusive.
- R9: `win_hit` follows `bus_addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe |
| reg_off | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| bus_addr | input | 32 | Address to be decoded |
| win_en | output | 1 | Window is valid |
| win_hit | output | 1 | Address falls inside the window |

## Verification
The hardest situation to reach is a bound write that arrives while the lock has just cleared itself. Such a write must be dropped, even though the write before it changed the same register. Random register traffic seldom produces this unlock, write, write ordering, so directed sequences force it. Directed sequences also cover inverted bounds and bounds that touch exactly the same 64 KB page. Random addresses are drawn close to the current bounds, so that the inclusive edges and the pages just outside them are hit often.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mwd_rst_sync.sv
module mwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mwd_regs.sv
module mwd_regs
  import mwd_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BOUND_W = 16,
  parameter int unsigned OFF_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [BOUND_W-1:0] low_bound,
  output logic [BOUND_W-1:0] high_bound
);
  localparam int unsigned PAD_W = DATA_W - BOUND_W;
  localparam logic [OFF_W-1:0] OFF_LOW  = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_HIGH = OFF_W'(4);
  localparam logic [OFF_W-1:0] OFF_LOCK = OFF_W'(8);

  reg_sel_e           sel;
  logic               bound_wr;
  logic               accept;
  logic [BOUND_W-1:0] low_q, low_d;
  logic [BOUND_W-1:0] high_q, high_d;
  logic               unlock_q, unlock_d;
  logic [DATA_W-1:0]  rd_val;
  logic [DATA_W-1:0]  rdata_q, rdata_d;

  always_comb begin
    if (off == OFF_LOW)       sel = SEL_LOW;
    else if (off == OFF_HIGH) sel = SEL_HIGH;
    else if (off == OFF_LOCK) sel = SEL_LOCK;
    else                      sel = SEL_NONE;
  end

  assign bound_wr = wr && ((sel == SEL_LOW) || (sel == SEL_HIGH));
  assign accept   = bound_wr && unlock_q;

  always_comb begin
    low_d    = low_q;
    high_d   = high_q;
    unlock_d = unlock_q;
    if (accept && (sel == SEL_LOW))  low_d  = wdata[DATA_W-1 -: BOUND_W];
    if (accept && (sel == SEL_HIGH)) high_d = wdata[DATA_W-1 -: BOUND_W];
    if (wr && (sel == SEL_LOCK))     unlock_d = wdata[0];
    else if (bound_wr)               unlock_d = 1'b0;
  end

  always_comb begin
    unique case (sel)
      SEL_LOW:  rd_val = {low_q, PAD_W'(0)};
      SEL_HIGH: rd_val = {high_q, PAD_W'(0)};
      SEL_LOCK: rd_val = {{(DATA_W-1){1'b0}}, unlock_q};
      default:  rd_val = '0;
    endcase
    rdata_d = rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= '0;
      high_q   <= '0;
      unlock_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      low_q    <= low_d;
      high_q   <= high_d;
      unlock_q <= unlock_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata      = rdata_q;
  assign low_bound  = low_q;
  assign high_bound = high_q;

  // R2: locked bound writes leave both bounds untouched
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bound_wr && !unlock_q) |=> ($stable(low_q) && $stable(high_q)));

  // R3: any bound write leaves the unlock bit cleared
  p_lock_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bound_wr |=> !unlock_q);

  // R4: unlock bit can only rise through a lock register write
  p_unlock_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock_q && !(wr && (sel == SEL_LOCK))) |=> !unlock_q);

  // R6: read data holds when no read is strobed
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));

  // R5: unused low bits of bound reads stay zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (sel != SEL_LOCK)) |=> (rdata_q[PAD_W-1:0] == '0));
endmodule

// File: rtl/mwd_match.sv
module mwd_match #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BOUND_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BOUND_W-1:0] low_bound,
  input  logic [BOUND_W-1:0] high_bound,
  input  logic [ADDR_W-1:0]  addr,
  output logic               win_en,
  output logic               win_hit
);
  logic [BOUND_W-1:0] page;
  logic               above_low;
  logic               below_high;

  assign page       = addr[ADDR_W-1 -: BOUND_W];
  assign win_en     = (high_bound != '0) && (low_bound <= high_bound);
  assign above_low  = (page >= low_bound);
  assign below_high = (page <= high_bound);
  assign win_hit    = win_en && above_low && below_high;

  // R7: a zero upper bound never produces a hit
  p_zero_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (high_bound == '0) |-> !win_hit);

  // R7: enable changes only when a bound changes
  p_en_follows_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(low_bound) && $stable(high_bound)) |-> $stable(win_en));

  // R8: hit implies window enabled
  p_hit_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> win_en);
endmodule

// File: rtl/mem_window_decode.sv
module mem_window_decode #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BOUND_W = 16,
  parameter int unsigned OFF_W   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              win_en,
  output logic              win_hit
);
  logic               core_rst_n;
  logic [BOUND_W-1:0] low_bound;
  logic [BOUND_W-1:0] high_bound;

  mwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  mwd_regs #(.DATA_W(DATA_W), .BOUND_W(BOUND_W), .OFF_W(OFF_W)) u_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .off        (reg_off),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .low_bound  (low_bound),
    .high_bound (high_bound)
  );

  mwd_match #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_match (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .low_bound  (low_bound),
    .high_bound (high_bound),
    .addr       (bus_addr),
    .win_en     (win_en),
    .win_hit    (win_hit)
  );
endmodule

// File: tb/test_mem_window_decode.sv
module test_mem_window_decode;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [3:0]  reg_off;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] bus_addr;
  logic        win_en;
  logic        win_hit;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_low;
  logic [15:0] m_high;
  logic        m_unlock;
  int unsigned seed;

  mem_window_decode i_mem_window_decode (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .win_en(win_en), .win_hit(win_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_en(logic [15:0] lo, logic [15:0] hi);
    return (hi != 16'h0) && (lo <= hi);
  endfunction

  function automatic logic exp_hit(logic [15:0] lo, logic [15:0] hi, logic [31:0] a);
    return exp_en(lo, hi) && (a[31:16] >= lo) && (a[31:16] <= hi);
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] off);
    case (off)
      4'h0:    return {m_low, 16'h0};
      4'h4:    return {m_high, 16'h0};
      4'h8:    return {31'h0, m_unlock};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] off, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
    if (off == 4'h8) m_unlock = data[0];
    else if (off == 4'h0 || off == 4'h4) begin
      if (m_unlock) begin
        if (off == 4'h0) m_low = data[31:16];
        else             m_high = data[31:16];
      end
      m_unlock = 1'b0;
    end
  endtask

  task automatic do_read(logic [3:0] off, string req);
    logic [31:0] e;
    @(negedge clk);
    reg_rd = 1'b1; reg_off = off;
    e = exp_read(off);
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, reg_rdata, e);
  endtask

  task automatic check_addr(logic [31:0] a, string req);
    bus_addr = a;
    #1;
    check({req, " en"}, {31'h0, win_en}, {31'h0, exp_en(m_low, m_high)});
    check({req, " hit"}, {31'h0, win_hit}, {31'h0, exp_hit(m_low, m_high, a)});
  endtask

  task automatic set_window(logic [15:0] lo, logic [15:0] hi);
    do_write(4'h8, 32'h1);
    do_write(4'h0, {lo, 16'h0});
    do_write(4'h8, 32'h1);
    do_write(4'h4, {hi, 16'h0});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    seed = 32'h1234_5678;
    reg_wr = 0; reg_rd = 0; reg_off = 0; reg_wdata = 0; bus_addr = 0;
    m_low = 0; m_high = 0; m_unlock = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", reg_rdata, 32'h0);
    check("R1 hit in reset", {31'h0, win_hit}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values through the port
    do_read(4'h0, "R1 low");
    do_read(4'h4, "R1 high");
    do_read(4'h8, "R1 lock");
    check_addr(32'h0000_1234, "R1");

    // R2 locked writes ignored
    do_write(4'h0, 32'h0005_0000);
    do_write(4'h4, 32'h0009_0000);
    do_read(4'h0, "R2 low locked");
    do_read(4'h4, "R2 high locked");

    // R4 lock register write and read back
    do_write(4'h8, 32'hFFFF_FFFF);
    do_read(4'h8, "R4 lock set");
    do_write(4'h8, 32'h0);
    do_read(4'h8, "R4 lock clear");

    // R3 one write per unlock
    do_write(4'h8, 32'h1);
    do_write(4'h4, 32'h0020_FFFF);
    do_read(4'h8, "R3 lock cleared");
    do_write(4'h4, 32'h0030_0000);
    do_read(4'h4, "R3 second write dropped");
    do_write(4'h8, 32'h1);
    do_write(4'h0, 32'h0010_ABCD);
    do_read(4'h0, "R5 low field");
    check_addr(32'h0010_0000, "R8 low edge");
    check_addr(32'h000F_FFFF, "R8 below low");
    check_addr(32'h0020_FFFF, "R8 high edge");
    check_addr(32'h0021_0000, "R8 above high");

    // R5 other offsets
    do_write(4'h8, 32'h1);
    do_write(4'hC, 32'hFFFF_FFFF);
    do_read(4'hC, "R5 unused offset");
    do_read(4'h8, "R5 lock untouched by unused offset");
    do_read(4'h0, "R5 low untouched");

    // R6 read data holds
    do_read(4'h4, "R6 read");
    hold = reg_rdata;
    repeat (3) @(negedge clk);
    check("R6 hold", reg_rdata, hold);
    do_write(4'h8, 32'h0);

    // R7 inverted bounds, equal bounds, zero high
    set_window(16'h0040, 16'h0030);
    check_addr(32'h0035_0000, "R7 inverted");
    set_window(16'h0040, 16'h0040);
    check_addr(32'h0040_FFFF, "R8 single page");
    check_addr(32'h0041_0000, "R8 single page above");
    set_window(16'h0000, 16'h0000);
    check_addr(32'h0000_0000, "R7 zero high");
    set_window(16'h0000, 16'hFFFF);
    check_addr(32'hFFFF_FFFF, "R8 full range");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [31:0] d;
      op = $urandom(seed) % 6;
      seed = seed + 32'h9E37;
      d = $urandom(seed);
      case (op)
        0: do_write(4'h8, {31'h0, d[0]});
        1: do_write(4'h0, d);
        2: do_write(4'h4, d);
        3: do_write(d[3:0], d);
        4: do_read(d[3:0], "R5 R6 random read");
        default: begin
          logic [15:0] pg;
          case (d[1:0])
            2'd0: pg = m_low - 16'(d[2]);
            2'd1: pg = m_high + 16'(d[2]);
            default: pg = d[31:16];
          endcase
          check_addr({pg, d[15:0]}, "R8 R9 random addr");
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule